// File: doc/BRIEF.md
# Modified Immediate Constant Expander

This block turns the packed immediate field of a 32-bit instruction word into the full 32-bit constant that the datapath uses, together with the shifter carry that goes with that constant. It knows two packings. The wide form rotates a byte right by an even amount. The compact form gathers twelve bits from three separate places in the word. Those twelve bits then either copy a byte into one of four lane patterns, or rotate a byte whose top bit is implied to be one.

The decode stage presents the instruction word, a form select and the current carry flag. One clock later, if the enable was high, the expanded constant and its carry appear on registered outputs. The same stage also presents three plainer immediates taken from the same word: a 12-bit field zero-extended to 32 bits, a 7-bit field scaled by four, and an 8-bit field scaled by four. These serve the instruction forms that need no expansion.

Top module: `imm_expander`

## Requirements
- R1: Wide form (form_sel=0) with instr[11:8]=0: imm_out = {24'b0, instr[7:0]} and carry_out = carry_in.
- R2: Wide form with instr[11:8]≠0: imm_out = {24'b0, instr[7:0]} rotated right by 2·instr[11:8] within 32 bits, and carry_out = imm_out[31].
- R3: Compact form (form_sel=1) takes its 12-bit field f as {instr[26], instr[14:12], instr[7:0]}, with instr[26] as f[11]. No other instruction bit affects imm_out or carry_out.
- R4: Compact form with f[11:10]=0 and byte B=f[7:0]: f[9:8]=0 gives 0x000000BB, 1 gives 0x00BB00BB, 2 gives 0xBB00BB00, 3 gives 0xBBBBBBBB. In all four cases carry_out = carry_in.
- R5: Compact form with f[11:10]≠0: imm_out = {24'b0, 1'b1, f[6:0]} rotated right by f[11:7], and carry_out = imm_out[31].
- R6: Whatever the form, imm12_out = zero-extended {instr[26], instr[14:12], instr[7:0]}, imm7x4_out = instr[6:0]·4, and imm8x4_out = instr[7:0]·4.
- R7: All outputs change only at a rising clock edge where en=1, and they take the values computed from the inputs sampled at that edge. At an edge where en=0, every output holds.
- R8: While rst_n is low, every output is zero.
- R9: carry_in never affects imm_out, imm12_out, imm7x4_out or imm8x4_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Capture enable for the output register |
| instr | input | 32 | Instruction word holding the immediate fields |
| form_sel | input | 1 | 0 = wide form, 1 = compact form |
| carry_in | input | 1 | Current carry flag |
| imm_out | output | 32 | Expanded immediate |
| carry_out | output | 1 | Carry produced by the expansion |
| imm12_out | output | 32 | Zero-extended 12-bit gathered field |
| imm7x4_out | output | 32 | instr[6:0] times four |
| imm8x4_out | output | 32 | instr[7:0] times four |

## Verification
In any one cycle, the expansion of the constant and the choice of carry happen together. The carry is either passed through from carry_in or taken from bit 31 of the result, and which one depends on the same field that decides the expansion. The bench provokes this by sending every wide-form encoding twice, once with each carry_in value, and by sending compact-form words that fall on both sides of the replicate/rotate boundary with either carry. For each word it judges the constant and the carry against a bit-serial rotation model. A second overlap is also exercised: the enable is dropped in the same cycle that the inputs change, and the bench requires every output to keep its previous value.

// File: rtl/imm_exp_pkg.sv
package imm_exp_pkg;
  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int LANES   = WORD_W / BYTE_W;
  localparam int FIELD_W = 12;
  localparam int ROT_W   = $clog2(WORD_W);

  typedef enum logic {
    FORM_WIDE    = 1'b0,
    FORM_COMPACT = 1'b1
  } form_e;

  typedef struct packed {
    logic [WORD_W-1:0] value;
    logic              carry;
  } imm_res_t;

  function automatic logic [WORD_W-1:0] ror_word(input logic [WORD_W-1:0] v,
                                                 input logic [ROT_W-1:0]  a);
    logic [2*WORD_W-1:0] dbl;
    dbl = {v, v} >> a;
    return dbl[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/imm_wide_expand.sv
module imm_wide_expand
  import imm_exp_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  input  logic              carry_in,
  output imm_res_t          res
);
  localparam int SEL_LO = BYTE_W;
  localparam int SEL_W  = 4;

  logic [SEL_W-1:0]  rot_sel;
  logic [ROT_W-1:0]  rot_amt;
  logic [WORD_W-1:0] base;
  logic [WORD_W-1:0] rotated;

  always_comb begin
    rot_sel = instr[SEL_LO +: SEL_W];
    rot_amt = {rot_sel, 1'b0};
    base    = {{(WORD_W-BYTE_W){1'b0}}, instr[BYTE_W-1:0]};
    rotated = ror_word(base, rot_amt);
    if (rot_sel == '0) begin
      res.value = base;
      res.carry = carry_in;
    end else begin
      res.value = rotated;
      res.carry = rotated[WORD_W-1];
    end
  end
endmodule

// File: rtl/imm_compact_expand.sv
module imm_compact_expand
  import imm_exp_pkg::*;
(
  input  logic [FIELD_W-1:0] field,
  input  logic               carry_in,
  output imm_res_t           res
);
  logic [1:0]        pat;
  logic [BYTE_W-1:0] byte_v;
  logic [LANES-1:0]  lane_on;
  logic [WORD_W-1:0] rep_word;
  logic [WORD_W-1:0] rot_word;
  logic              use_rot;

  assign pat     = field[9:8];
  assign byte_v  = field[BYTE_W-1:0];
  assign use_rot = |field[11:10];

  // Per-lane enable: even lanes carry the byte in patterns 1 and 3
  // (and lane 0 in pattern 0); odd lanes in patterns 2 and 3.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if ((i % 2) == 0) begin : g_even
      if (i == 0) begin : g_low
        assign lane_on[i] = (pat != 2'd2);
      end else begin : g_hi
        assign lane_on[i] = pat[0];
      end
    end else begin : g_odd
      assign lane_on[i] = pat[1];
    end
    assign rep_word[i*BYTE_W +: BYTE_W] = lane_on[i] ? byte_v : '0;
  end

  always_comb begin
    rot_word = ror_word({{(WORD_W-BYTE_W){1'b0}}, 1'b1, field[BYTE_W-2:0]},
                        field[FIELD_W-1 -: ROT_W]);
    if (use_rot) begin
      res.value = rot_word;
      res.carry = rot_word[WORD_W-1];
    end else begin
      res.value = rep_word;
      res.carry = carry_in;
    end
  end
endmodule

// File: rtl/imm_aux_fields.sv
module imm_aux_fields
  import imm_exp_pkg::*;
(
  input  logic [WORD_W-1:0]  instr,
  output logic [FIELD_W-1:0] field,
  output logic [WORD_W-1:0]  imm12,
  output logic [WORD_W-1:0]  imm7x4,
  output logic [WORD_W-1:0]  imm8x4
);
  localparam int HI_BIT = 26;
  localparam int MID_LO = 12;
  localparam int MID_W  = 3;
  localparam int SCALE  = 2;

  assign field  = {instr[HI_BIT], instr[MID_LO +: MID_W], instr[BYTE_W-1:0]};
  assign imm12  = {{(WORD_W-FIELD_W){1'b0}}, field};
  assign imm7x4 = {{(WORD_W-BYTE_W+1-SCALE){1'b0}}, instr[BYTE_W-2:0], {SCALE{1'b0}}};
  assign imm8x4 = {{(WORD_W-BYTE_W-SCALE){1'b0}}, instr[BYTE_W-1:0], {SCALE{1'b0}}};
endmodule

// File: rtl/imm_expander.sv
module imm_expander
  import imm_exp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WORD_W-1:0] instr,
  input  logic              form_sel,
  input  logic              carry_in,
  output logic [WORD_W-1:0] imm_out,
  output logic              carry_out,
  output logic [WORD_W-1:0] imm12_out,
  output logic [WORD_W-1:0] imm7x4_out,
  output logic [WORD_W-1:0] imm8x4_out
);
  logic [FIELD_W-1:0] field;
  logic [WORD_W-1:0]  imm12_c, imm7x4_c, imm8x4_c;
  imm_res_t           wide_res, compact_res, sel_res;
  form_e              form;

  logic [WORD_W-1:0]  imm_q, imm12_q, imm7x4_q, imm8x4_q;
  logic               carry_q;
  logic [WORD_W-1:0]  imm_d, imm12_d, imm7x4_d, imm8x4_d;
  logic               carry_d;

  assign form = form_e'(form_sel);

  imm_aux_fields u_aux (
    .instr  (instr),
    .field  (field),
    .imm12  (imm12_c),
    .imm7x4 (imm7x4_c),
    .imm8x4 (imm8x4_c)
  );

  imm_wide_expand u_wide (
    .instr    (instr),
    .carry_in (carry_in),
    .res      (wide_res)
  );

  imm_compact_expand u_compact (
    .field    (field),
    .carry_in (carry_in),
    .res      (compact_res)
  );

  assign sel_res = (form == FORM_COMPACT) ? compact_res : wide_res;

  // Next-state: capture when enabled, otherwise hold.
  always_comb begin
    if (en) begin
      imm_d    = sel_res.value;
      carry_d  = sel_res.carry;
      imm12_d  = imm12_c;
      imm7x4_d = imm7x4_c;
      imm8x4_d = imm8x4_c;
    end else begin
      imm_d    = imm_q;
      carry_d  = carry_q;
      imm12_d  = imm12_q;
      imm7x4_d = imm7x4_q;
      imm8x4_d = imm8x4_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm_q    <= '0;
      carry_q  <= 1'b0;
      imm12_q  <= '0;
      imm7x4_q <= '0;
      imm8x4_q <= '0;
    end else begin
      imm_q    <= imm_d;
      carry_q  <= carry_d;
      imm12_q  <= imm12_d;
      imm7x4_q <= imm7x4_d;
      imm8x4_q <= imm8x4_d;
    end
  end

  assign imm_out    = imm_q;
  assign carry_out  = carry_q;
  assign imm12_out  = imm12_q;
  assign imm7x4_out = imm7x4_q;
  assign imm8x4_out = imm8x4_q;
endmodule

// File: rtl/imm_expander_chk.sv
module imm_expander_chk
  import imm_exp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [WORD_W-1:0] instr,
  input logic              form_sel,
  input logic              carry_in,
  input logic [WORD_W-1:0] imm_out,
  input logic              carry_out,
  input logic [WORD_W-1:0] imm12_out,
  input logic [WORD_W-1:0] imm7x4_out,
  input logic [WORD_W-1:0] imm8x4_out
);
  // R7: a disabled edge leaves every output unchanged
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(en)) |->
      ($stable(imm_out) && $stable(carry_out) && $stable(imm12_out) &&
       $stable(imm7x4_out) && $stable(imm8x4_out)));

  // R1: unrotated wide form passes the carry and keeps upper bits clear
  p_wide_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && en && !form_sel && (instr[11:8] == 4'd0)) |->
      (carry_out == $past(carry_in)) && (imm_out[31:8] == '0));

  // R2: rotated wide form takes carry from the result's top bit
  p_wide_rot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && en && !form_sel && (instr[11:8] != 4'd0)) |->
      (carry_out == imm_out[31]) && ($countones(imm_out) == $countones($past(instr[7:0]))));

  // R4: replicate path passes the carry through
  p_rep_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && en && form_sel && !instr[26] && !instr[14]) |->
      (carry_out == $past(carry_in)));

  // R5: rotate path keeps the implied one and takes carry from bit 31
  p_rot_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && en && form_sel && (instr[26] || instr[14])) |->
      (carry_out == imm_out[31]) && ($countones(imm_out) == 1 + $countones($past(instr[6:0]))));

  // R6: scaled outputs are multiples of four within their field span
  p_aux_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && en) |->
      (imm7x4_out[1:0] == 2'b00) && (imm7x4_out[31:9] == '0) &&
      (imm8x4_out[1:0] == 2'b00) && (imm8x4_out[31:10] == '0) &&
      (imm12_out[31:12] == '0));
endmodule

bind imm_expander imm_expander_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .instr      (instr),
  .form_sel   (form_sel),
  .carry_in   (carry_in),
  .imm_out    (imm_out),
  .carry_out  (carry_out),
  .imm12_out  (imm12_out),
  .imm7x4_out (imm7x4_out),
  .imm8x4_out (imm8x4_out)
);

// File: tb/imm_expander_tb.sv
module imm_expander_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [31:0] instr;
  logic        form_sel;
  logic        carry_in;
  logic [31:0] imm_out, imm12_out, imm7x4_out, imm8x4_out;
  logic        carry_out;

  int checks = 0;
  int errors = 0;

  logic [31:0] e_imm, e_imm12, e_imm7, e_imm8;
  logic        e_carry;

  always #10 clk = ~clk;

  imm_expander u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .instr(instr), .form_sel(form_sel),
    .carry_in(carry_in), .imm_out(imm_out), .carry_out(carry_out),
    .imm12_out(imm12_out), .imm7x4_out(imm7x4_out), .imm8x4_out(imm8x4_out)
  );

  function automatic logic [31:0] rot_r(input logic [31:0] v, input int n);
    logic [31:0] x = v;
    for (int k = 0; k < n; k++) x = {x[0], x[31:1]};
    return x;
  endfunction

  // Behavioural model of the requirements; tag names the requirement exercised.
  task automatic model(input logic [31:0] w, input logic f, input logic c,
                       output logic [31:0] v, output logic co, output string tag);
    int field, amt;
    logic [31:0] b;
    if (!f) begin
      amt = 2 * int'(w[11:8]);
      v   = rot_r({24'd0, w[7:0]}, amt);
      if (amt == 0) begin co = c; tag = "R1"; end
      else begin co = v[31]; tag = "R2"; end
    end else begin
      field = (int'(w[26]) * 2048) + (int'(w[14:12]) * 256) + int'(w[7:0]);
      b = {24'd0, w[7:0]};
      if (field < 1024) begin
        case (field / 256)
          0: v = b;
          1: v = b * 32'h0001_0001;
          2: v = b * 32'h0100_0100;
          default: v = b * 32'h0101_0101;
        endcase
        co = c; tag = "R4 R3";
      end else begin
        v  = rot_r(32'd128 + (field % 128), field / 128);
        co = v[31]; tag = "R5 R3";
      end
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (imm_out !== e_imm || carry_out !== e_carry) begin
      errors++;
      $display("FAIL %s: imm=%h carry=%b expected imm=%h carry=%b",
               tag, imm_out, carry_out, e_imm, e_carry);
    end
    checks++;
    if (imm12_out !== e_imm12 || imm7x4_out !== e_imm7 || imm8x4_out !== e_imm8) begin
      errors++;
      $display("FAIL R6 (%s): aux=%h/%h/%h expected %h/%h/%h", tag,
               imm12_out, imm7x4_out, imm8x4_out, e_imm12, e_imm7, e_imm8);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check at the next fall.
  task automatic step(input logic [31:0] w, input logic f, input logic c,
                      input logic e, input string extra);
    logic [31:0] v; logic co; string tag;
    instr = w; form_sel = f; carry_in = c; en = e;
    model(w, f, c, v, co, tag);
    if (e) begin
      e_imm = v; e_carry = co;
      e_imm12 = {20'd0, w[26], w[14:12], w[7:0]};
      e_imm7  = {23'd0, w[6:0], 2'b00};
      e_imm8  = {22'd0, w[7:0], 2'b00};
    end else begin
      tag = "R7 hold";
    end
    @(negedge clk);
    compare({tag, " ", extra});
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; instr = 32'hFFFF_FFFF; form_sel = 1'b0; carry_in = 1'b1;
    e_imm = '0; e_carry = 1'b0; e_imm12 = '0; e_imm7 = '0; e_imm8 = '0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    compare("R8 reset");
    rst_n = 1'b1;

    // Every wide encoding with both carries (R1 R2 R9).
    for (int k = 0; k < 4096; k++) begin
      for (int c = 0; c < 2; c++) begin
        step({$urandom()} & 32'hFFFF_F000 | k, 1'b0, c[0], 1'b1, "R9");
      end
    end

    // Compact form: each replicate pattern and rotate boundaries (R3 R4 R5).
    step(32'h0000_00A5, 1'b1, 1'b1, 1'b1, "pat0");
    step(32'h0000_10A5, 1'b1, 1'b0, 1'b1, "pat1");
    step(32'h0000_20A5, 1'b1, 1'b1, 1'b1, "pat2");
    step(32'h0000_30A5, 1'b1, 1'b0, 1'b1, "pat3");
    step(32'hFBFF_8F00, 1'b1, 1'b1, 1'b1, "R3 stray bits ignored");
    step(32'h0000_4000, 1'b1, 1'b0, 1'b1, "rot by 8");
    step(32'h0400_70FF, 1'b1, 1'b0, 1'b1, "rot by 31");
    step(32'h0400_707F, 1'b1, 1'b1, 1'b1, "rot by 30 R9");

    // Enable low while inputs change (R7).
    step(32'h0000_0F01, 1'b0, 1'b0, 1'b1, "pre-hold");
    step(32'h0400_7FFF, 1'b1, 1'b1, 1'b0, "R7");
    step(32'h0000_00FF, 1'b0, 1'b1, 1'b0, "R7");

    // Random compact words.
    for (int k = 0; k < 3000; k++) begin
      step($urandom(), 1'b1, k[0], 1'b1, "random");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule